// File: doc/BRIEF.md
# Functional Unit Writeback Busy Table

This block serves one dequeue port of an issue queue. The execution unit behind that port holds several functional units with different fixed latencies, but it has only one writeback port, so no two instructions may finish in the same cycle. The block keeps a vector of future writeback slots that are already taken. The vector moves one slot closer to the present every clock. From it the block drives one blocking bit per latency class. The issue selector on the same port must not pick a candidate whose latency class is blocked.

An instruction issued with latency L in cycle t writes back in cycle t+L. The record of a dequeue comes in on a valid strobe with its latency. The table has no ready signal and never applies back-pressure: it accepts every valid dequeue in the cycle it is presented. A cancel input releases a reservation when an issued instruction is called back. A flush drops every reservation. Both are plain control pins. Latency classes run from 0 to `MAX_LAT`, and the class code is the latency in binary.

Top module: `fu_wb_busy_table`

## Requirements
- R1: After reset, and after a reset applied while reservations exist, every bit of `blk_mask` is 0.
- R2: A dequeue with latency code L, 1 <= L <= MAX_LAT, in cycle t makes `blk_mask[L-1]` equal to 1 in cycle t+1.
- R3: A reservation advances one class lower per cycle. For a dequeue of latency L in cycle t, `blk_mask[L-k]` is 1 in cycle t+k for k = 1..L, and the reservation is gone in cycle t+L+1.
- R4: A dequeue with latency code 0 reserves nothing.
- R5: A dequeue with a latency code above MAX_LAT reserves nothing.
- R6: `cancel_valid` with slot code S, 1 <= S <= MAX_LAT-1, in cycle t removes the reservation that `blk_mask[S]` shows in cycle t, so `blk_mask[S-1]` is 0 in cycle t+1. Other reservations still advance normally. Cancelling a slot that holds no reservation changes nothing.
- R7: `flush` clears every reservation in the next cycle, including one from a dequeue in the same cycle.
- R8: `blk_mask[MAX_LAT]` is always 0.
- R9: A latency-2 dequeue in cycle t sets `blk_mask[0]` in cycle t+2, so a latency-0 issue that would finish together with it is blocked. The port never dequeues a class whose mask bit is set.
- R10: Reservations from different dequeues coexist in the vector and advance independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all reservations |
| deq_valid | input | 1 | An instruction is dequeued on this port this cycle |
| deq_lat | input | LAT_W | Latency class of the dequeued instruction |
| cancel_valid | input | 1 | Release one reservation |
| cancel_slot | input | LAT_W | Cycles until writeback of the reservation to release |
| blk_mask | output | MAX_LAT+1 | Bit L set: issuing latency L now collides |

## Verification
The table is driven with single dequeues of each latency, which separates a correct slot position from an off-by-one in the setting logic. Interleaved dequeues of mixed latencies show whether reservations merge or overwrite each other. Latency codes 0 and above the maximum show whether out-of-range codes leak into the vector. Cancels of occupied and empty slots, and flushes that coincide with a dequeue, tell a selective release apart from a wholesale one and from an ordering mistake between clearing and setting.

// File: rtl/fu_wbb_pkg.sv
`timescale 1ns/1ps
package fu_wbb_pkg;
  parameter int unsigned DEF_MAX_LAT = 4;

  function automatic int unsigned lat_width(input int unsigned max_lat);
    return (max_lat < 1) ? 1 : $clog2(max_lat + 1);
  endfunction
endpackage

// File: rtl/wbb_slot_decode.sv
`timescale 1ns/1ps
// Turns a qualified index into a one-hot slot vector; codes outside the
// vector select nothing.
module wbb_slot_decode #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned OFFSET = 0
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [SLOTS-1:0] onehot
);
  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    assign onehot[j] = en && (idx == IDX_W'(j + OFFSET));
  end
endmodule

// File: rtl/wbb_resv_shift.sv
`timescale 1ns/1ps
// Future-writeback reservation register: bit j = a writeback is booked
// j cycles from now.
module wbb_resv_shift #(
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SLOTS-1:0] set_vec,
  input  logic [SLOTS-1:0] clr_vec,
  output logic [SLOTS-1:0] busy_q
);
  logic [SLOTS-1:0] kept;
  logic [SLOTS-1:0] busy_d;

  always_comb begin
    kept   = busy_q & ~clr_vec;
    busy_d = (kept >> 1) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) busy_q <= '0;
    else                 busy_q <= busy_d;
  end

  // R7: a flush leaves no reservation behind
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_q == '0));

  // R6: a released slot does not reappear one position lower
  for (genvar j = 1; j < SLOTS; j++) begin : g_cancel_chk
    a_r6_cancel_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[j] && !set_vec[j-1] && !flush) |=> !busy_q[j-1]);
  end

  // R3: without flush or cancel, every held reservation moves down by one
  if (SLOTS >= 2) begin : g_shift_chk
    a_r3_shift_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && (clr_vec == '0)) |=>
        ((~busy_q[SLOTS-2:0] & $past(busy_q[SLOTS-1:1])) == '0));
  end
endmodule

// File: rtl/fu_wb_busy_table.sv
`timescale 1ns/1ps
module fu_wb_busy_table #(
  parameter int unsigned MAX_LAT = fu_wbb_pkg::DEF_MAX_LAT,
  parameter int unsigned LAT_W   = fu_wbb_pkg::lat_width(MAX_LAT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               deq_valid,
  input  logic [LAT_W-1:0]   deq_lat,
  input  logic               cancel_valid,
  input  logic [LAT_W-1:0]   cancel_slot,
  output logic [MAX_LAT:0]   blk_mask
);
  localparam int unsigned SLOTS = (MAX_LAT < 1) ? 1 : MAX_LAT;
  localparam logic [LAT_W-1:0] LAT_TOP = LAT_W'(MAX_LAT);

  logic [SLOTS-1:0] set_vec;
  logic [SLOTS-1:0] clr_vec;
  logic [SLOTS-1:0] busy_q;

  // latency L lands at slot L-1 once the vector has advanced
  wbb_slot_decode #(.SLOTS(SLOTS), .IDX_W(LAT_W), .OFFSET(1)) u_set_dec (
    .en(deq_valid), .idx(deq_lat), .onehot(set_vec));

  // a cancel addresses the slot as seen this cycle
  wbb_slot_decode #(.SLOTS(SLOTS), .IDX_W(LAT_W), .OFFSET(0)) u_clr_dec (
    .en(cancel_valid), .idx(cancel_slot), .onehot(clr_vec));

  wbb_resv_shift #(.SLOTS(SLOTS)) u_resv (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .set_vec(set_vec), .clr_vec(clr_vec), .busy_q(busy_q));

  assign blk_mask = {1'b0, busy_q[MAX_LAT-1:0]};

  // R2: an in-range dequeue shows up one class lower on the next cycle
  a_r2_issue_books: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !flush && (deq_lat >= LAT_W'(1)) && (deq_lat <= LAT_TOP))
      |=> blk_mask[$past(deq_lat) - LAT_W'(1)]);

  // R4/R5: codes 0 or beyond the top add no reservation
  a_r5_no_book_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && ((deq_lat == '0) || (deq_lat > LAT_TOP)))
      |=> ($countones(blk_mask) <= $past($countones(blk_mask))));

  // R9: the port never issues into an occupied writeback slot
  a_r9_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && (deq_lat <= LAT_TOP)) |-> !blk_mask[deq_lat]);
endmodule

// File: tb/fu_wb_busy_table_bench.sv
`timescale 1ns/1ps
module fu_wb_busy_table_bench;
  localparam int unsigned MAX_LAT = 4;
  localparam int unsigned LAT_W   = 3;
  localparam int unsigned NROW    = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic deq_valid = 1'b0;
  logic [LAT_W-1:0] deq_lat = '0;
  logic cancel_valid = 1'b0;
  logic [LAT_W-1:0] cancel_slot = '0;
  logic [MAX_LAT:0] blk_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fu_wb_busy_table #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_fu_wb_busy_table (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .deq_valid(deq_valid), .deq_lat(deq_lat),
    .cancel_valid(cancel_valid), .cancel_slot(cancel_slot),
    .blk_mask(blk_mask));

  // row: flush, deq_valid, deq_lat[3], cancel_valid, cancel_slot[3], expected mask[5]
  localparam logic [13:0] VEC [NROW] = '{
    {1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 5'b00010},  // R2 latency 2 booked
    {1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 5'b00001},  // R9 latency 0 blocked
    {1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 5'b00000},  // R3 reservation retired
    {1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 5'b01000},  // R2 top latency
    {1'b0, 1'b1, 3'd1, 1'b0, 3'd0, 5'b00101},  // R10 two coexist
    {1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 5'b00010},  // R10 both advance
    {1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 5'b00001},  // R4 latency 0 books nothing
    {1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 5'b00100},  // R2 latency 3
    {1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 5'b00000},  // R6 cancel occupied slot
    {1'b0, 1'b1, 3'd6, 1'b0, 3'd0, 5'b00000},  // R5 code beyond top
    {1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 5'b01000},  // R2 refill
    {1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 5'b00110},  // R10 interleave
    {1'b1, 1'b1, 3'd4, 1'b0, 3'd0, 5'b00000},  // R7 flush beats dequeue
    {1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 5'b00100},  // R2 after flush
    {1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 5'b00010},  // R6 cancel empty slot
    {1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 5'b00001},  // R3 advance
    {1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 5'b00000}   // R3 retire
  };

  task automatic check(input string req, input logic [MAX_LAT:0] act,
                       input logic [MAX_LAT:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: blk_mask=%b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flush = 1'b0; deq_valid = 1'b0; deq_lat = '0;
    cancel_valid = 1'b0; cancel_slot = '0;
  endtask

  // apply inputs for one cycle, then sample after the edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step();
    step();
    check("R1 reset", blk_mask, '0);
    rst_n = 1'b1;

    for (int i = 0; i < int'(NROW); i++) begin
      flush        = VEC[i][13];
      deq_valid    = VEC[i][12];
      deq_lat      = VEC[i][11:9];
      cancel_valid = VEC[i][8];
      cancel_slot  = VEC[i][7:5];
      step();
      check($sformatf("row %0d", i), blk_mask, VEC[i][4:0]);
      check("R8 top class", {4'b0, blk_mask[MAX_LAT]}, '0);
    end
    idle_inputs();

    // R3: a latency-4 reservation walks down one class per cycle
    deq_valid = 1'b1; deq_lat = 3'd4;
    step();
    idle_inputs();
    check("R3 k=1", blk_mask, 5'b01000);
    for (int k = 2; k <= 4; k++) begin
      step();
      check("R3 walk", blk_mask, 5'(1 << (4 - k)));
    end
    step();
    check("R3 gone", blk_mask, '0);

    // R9: latency 2 blocks latency 0 two cycles later
    deq_valid = 1'b1; deq_lat = 3'd2;
    step();
    idle_inputs();
    step();
    check("R9 lat0 blocked", {4'b0, blk_mask[0]}, 5'b00001);
    step();

    // R1: reset during flight
    deq_valid = 1'b1; deq_lat = 3'd4;
    step();
    idle_inputs();
    deq_valid = 1'b1; deq_lat = 3'd2;
    step();
    idle_inputs();
    check("R10 pre-reset", blk_mask, 5'b00110);
    rst_n = 1'b0;
    step();
    check("R1 reset in flight", blk_mask, '0);
    rst_n = 1'b1;
    step();
    check("R1 stays clear", blk_mask, '0);

    finish_run();
  end
endmodule